// File: doc/BRIEF.md
# Dual-Bank Memory Cycle Controller

This block connects a CPU sequencer to a memory built as two banks of 32K words each. Only one bank can run a cycle at a time. The CPU issues a read call or a write call at its T1 phase. The controller then starts the cycle timer of exactly one bank. That timer runs a fixed 40-tick cycle on a 25 ns base clock.

For reads, the bank is chosen from two early hints, sampled with the call. The high-bank hint arrives before the address register has settled. The local-storage hint forces the low bank. For writes, the bank is chosen from the settled high-order address bit.

During a read cycle the controller raises a sense-strobe window and a data-ready pulse. On the first tick of data-ready it captures the nine sense lines (parity plus eight data bits) into a data register. It does this only when the CPU has selected memory as that register's source. The register outputs drive the nine store lines directly.

Top module: `mem_cycle_ctrl`

## Requirements
- R1: After reset both bank timers are idle, `busy`, `strobe` and `data_ready` are 0, `bank_active` is 2'b00 and `store_bits` is zero.
- R2: On an accepted read call, bank 1 starts (`bank_active` = 2'b10) if `hint_high` is 1 and `hint_local` is 0 on the same edge; otherwise bank 0 starts (`bank_active` = 2'b01).
- R3: When `hint_local` is 1 on an accepted read call, bank 0 starts, even if `hint_high` is also 1.
- R4: On an accepted write call, bank 1 starts when `addr_msb` is 1 and bank 0 when it is 0; the hints have no effect; `cycle_is_write` reads 1 for the whole cycle.
- R5: Consider the clock edge that accepts a call, and call the cycle that follows it tick 0. `busy` is then high for ticks 0 through 39 and low at tick 40.
- R6: `strobe` is high exactly during ticks 21 through 31 of a read cycle and never during a write cycle.
- R7: `data_ready` is high exactly during ticks 30 through 35 of a read cycle and never during a write cycle.
- R8: At the end of tick 30 of a read cycle, `store_bits` takes the value of `sense_bits` if `src_mem` is 1. It does not change at any other time, and it does not change when `src_mem` is 0.
- R9: A read call or write call that arrives while `busy` is 1 is ignored: the running cycle keeps its bank, its type and its length.
- R10: At most one bit of `bank_active` is ever set.
- R11: When `read_call` and `write_call` are both 1 on an idle edge, a read cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one tick per period |
| rst | input | 1 | Synchronous active-high reset |
| read_call | input | 1 | Read request at T1 |
| write_call | input | 1 | Write request at T1 |
| hint_high | input | 1 | Early hint: next read goes to bank 1 |
| hint_local | input | 1 | Early hint: next read goes to bank 0 (overrides hint_high) |
| addr_msb | input | 1 | Settled high-order address bit, used for writes |
| src_mem | input | 1 | CPU has chosen memory as the data register source |
| sense_bits | input | 9 | Sense lines, bit 8 parity, bits 7..0 data |
| busy | output | 1 | A bank cycle is running |
| bank_active | output | 2 | One-hot running bank, bit 0 low bank, bit 1 high bank |
| cycle_is_write | output | 1 | Running cycle is a write |
| strobe | output | 1 | Sense-strobe window |
| data_ready | output | 1 | Data-ready pulse |
| store_bits | output | 9 | Data register, driven to the store lines |

## Verification
On every cycle the assertions check that only one bank runs at a time. They check that strobe and data-ready appear only inside a running read cycle. They check that the data register changes only on the first data-ready tick while memory is the source. They also check that the hints and the address bit pick the bank that starts.

Only the scenarios can show the exact tick positions of the windows and the 40-tick length of a cycle. The same holds for calls ignored while busy, for read priority over a simultaneous write, and for sense values changed after capture leaving the register untouched.

// File: rtl/mem_cycle_pkg.sv
package mem_cycle_pkg;
    localparam int DATA_W       = 9;
    localparam int CYCLE_TICKS  = 40;
    localparam int STROBE_FIRST = 21;
    localparam int STROBE_LAST  = 31;
    localparam int READY_FIRST  = 30;
    localparam int READY_LAST   = 35;
    localparam int NUM_BANKS    = 2;

    typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_e;

    typedef struct packed {
        logic  start;
        logic  is_write;
        bank_e bank;
    } launch_t;

    function automatic bank_e pick_bank(input logic is_write, input logic hi,
                                        input logic loc, input logic msb);
        if (is_write)
            return msb ? BANK_HI : BANK_LO;
        else if (loc)
            return BANK_LO;
        else
            return hi ? BANK_HI : BANK_LO;
    endfunction
endpackage

// File: rtl/mem_bank_select.sv
module mem_bank_select
    import mem_cycle_pkg::*;
(
    input  logic    read_call,
    input  logic    write_call,
    input  logic    hint_high,
    input  logic    hint_local,
    input  logic    addr_msb,
    input  logic    busy,
    output launch_t launch
);
    logic want_write;

    always_comb begin
        want_write      = write_call && !read_call;
        launch.start    = (read_call || write_call) && !busy;
        launch.is_write = want_write;
        launch.bank     = pick_bank(want_write, hint_high, hint_local, addr_msb);
    end
endmodule

// File: rtl/mem_bank_timer.sv
module mem_bank_timer
    import mem_cycle_pkg::*;
#(
    parameter int TICKS  = CYCLE_TICKS,
    parameter int S_LO   = STROBE_FIRST,
    parameter int S_HI   = STROBE_LAST,
    parameter int R_LO   = READY_FIRST,
    parameter int R_HI   = READY_LAST
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_write,
    output logic running,
    output logic is_write,
    output logic strobe,
    output logic ready,
    output logic ready_first
);
    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            is_write <= 1'b0;
            count    <= '0;
        end else if (start && !running) begin
            running  <= 1'b1;
            is_write <= start_write;
            count    <= '0;
        end else if (running) begin
            if (count == LAST) begin
                running <= 1'b0;
                count   <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    always_comb begin
        strobe      = running && !is_write && (count >= CW'(S_LO)) && (count <= CW'(S_HI));
        ready       = running && !is_write && (count >= CW'(R_LO)) && (count <= CW'(R_HI));
        ready_first = running && !is_write && (count == CW'(R_LO));
    end
endmodule

// File: rtl/mem_data_reg.sv
module mem_data_reg
    import mem_cycle_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/mem_cycle_ctrl.sv
module mem_cycle_ctrl
    import mem_cycle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              read_call,
    input  logic              write_call,
    input  logic              hint_high,
    input  logic              hint_local,
    input  logic              addr_msb,
    input  logic              src_mem,
    input  logic [DATA_W-1:0] sense_bits,
    output logic              busy,
    output logic [NUM_BANKS-1:0] bank_active,
    output logic              cycle_is_write,
    output logic              strobe,
    output logic              data_ready,
    output logic [DATA_W-1:0] store_bits
);
    launch_t launch;
    logic [NUM_BANKS-1:0] t_write, t_strobe, t_ready, t_first;

    mem_bank_select u_sel (
        .read_call (read_call),
        .write_call(write_call),
        .hint_high (hint_high),
        .hint_local(hint_local),
        .addr_msb  (addr_msb),
        .busy      (busy),
        .launch    (launch)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mem_bank_timer u_timer (
            .clk        (clk),
            .rst        (rst),
            .start      (launch.start && (int'(launch.bank) == b)),
            .start_write(launch.is_write),
            .running    (bank_active[b]),
            .is_write   (t_write[b]),
            .strobe     (t_strobe[b]),
            .ready      (t_ready[b]),
            .ready_first(t_first[b])
        );
    end

    always_comb begin
        busy           = |bank_active;
        cycle_is_write = |(t_write & bank_active);
        strobe         = |t_strobe;
        data_ready     = |t_ready;
    end

    mem_data_reg u_dreg (
        .clk (clk),
        .rst (rst),
        .load((|t_first) && src_mem),
        .d   (sense_bits),
        .q   (store_bits)
    );
endmodule

// File: rtl/mem_cycle_ctrl_chk.sv
module mem_cycle_ctrl_chk
    import mem_cycle_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              read_call,
    input logic              write_call,
    input logic              hint_high,
    input logic              hint_local,
    input logic              addr_msb,
    input logic              src_mem,
    input logic [DATA_W-1:0] sense_bits,
    input logic              busy,
    input logic [NUM_BANKS-1:0] bank_active,
    input logic              cycle_is_write,
    input logic              strobe,
    input logic              data_ready,
    input logic [DATA_W-1:0] store_bits
);
    p_one_bank_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_active));

    p_strobe_read_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (busy && !cycle_is_write));

    p_ready_read_r7: assert property (@(posedge clk) disable iff (rst)
        data_ready |-> (busy && !cycle_is_write));

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(data_ready) && src_mem) |=> (store_bits == $past(sense_bits)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !($rose(data_ready) && src_mem) |=> $stable(store_bits));

    p_high_hint_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && read_call && hint_high && !hint_local) |=> (bank_active == 2'b10));

    p_local_hint_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && read_call && hint_local) |=> (bank_active == 2'b01));

    p_write_msb_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && write_call && !read_call) |=>
            (cycle_is_write && bank_active == (addr_msb ? 2'b01 : 2'b10) ? 1'b0 :
             cycle_is_write && bank_active[$past(addr_msb)]));
endmodule

bind mem_cycle_ctrl mem_cycle_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .read_call(read_call), .write_call(write_call),
    .hint_high(hint_high), .hint_local(hint_local), .addr_msb(addr_msb),
    .src_mem(src_mem), .sense_bits(sense_bits), .busy(busy),
    .bank_active(bank_active), .cycle_is_write(cycle_is_write),
    .strobe(strobe), .data_ready(data_ready), .store_bits(store_bits)
);

// File: tb/mem_cycle_ctrl_bench.sv
module mem_cycle_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic read_call = 0, write_call = 0, hint_high = 0, hint_local = 0;
    logic addr_msb = 0, src_mem = 0;
    logic [8:0] sense_bits = '0;
    logic busy, cycle_is_write, strobe, data_ready;
    logic [1:0] bank_active;
    logic [8:0] store_bits;

    int total = 0;
    int bad = 0;
    logic [8:0] exp_store = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_cycle_ctrl u_mem_cycle_ctrl (
        .clk(clk), .rst(rst), .read_call(read_call), .write_call(write_call),
        .hint_high(hint_high), .hint_local(hint_local), .addr_msb(addr_msb),
        .src_mem(src_mem), .sense_bits(sense_bits), .busy(busy),
        .bank_active(bank_active), .cycle_is_write(cycle_is_write),
        .strobe(strobe), .data_ready(data_ready), .store_bits(store_bits)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One full cycle: launch, then check every tick 0..40.
    task automatic run_cycle(input string req, input logic rd, input logic wr,
                             input logic hi, input logic loc, input logic msb,
                             input logic srcm, input logic [8:0] sense,
                             input logic [1:0] exp_bank, input logic exp_wr,
                             input logic poke);
        logic mismatch;
        @(negedge clk);
        read_call = rd; write_call = wr; hint_high = hi; hint_local = loc;
        addr_msb = msb; src_mem = srcm; sense_bits = sense;
        @(negedge clk);
        read_call = 0; write_call = 0; hint_high = 0; hint_local = 0;
        check({req, " bank"}, bank_active, exp_bank);
        check({req, " type"}, cycle_is_write, exp_wr);
        mismatch = 0;
        for (int k = 0; k < 40; k++) begin
            if (k > 0) @(negedge clk);
            if (busy !== 1'b1) mismatch = 1;
            if (bank_active !== exp_bank) mismatch = 1;
            if (strobe !== (!exp_wr && k >= 21 && k <= 31)) mismatch = 1;
            if (data_ready !== (!exp_wr && k >= 30 && k <= 35)) mismatch = 1;
            if (k == 10 && poke) begin
                // R9: second call while busy, with opposite settings
                read_call = !rd; write_call = rd; addr_msb = !msb;
                hint_high = !hi; hint_local = !loc;
            end
            if (k == 11) begin
                read_call = 0; write_call = 0; hint_high = 0; hint_local = 0;
            end
            if (k == 31) begin
                if (!exp_wr && srcm) exp_store = sense;
                check({req, " R8 store after capture"}, store_bits, exp_store);
                sense_bits = ~sense;
            end
            if (k == 36)
                check({req, " R8 store held"}, store_bits, exp_store);
        end
        check({req, " R5/R6/R7 tick profile"}, mismatch, 0);
        @(negedge clk);
        check({req, " R5 busy ends at tick 40"}, busy, 0);
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 bank", bank_active, 0);
        check("R1 strobe", strobe, 0);
        check("R1 ready", data_ready, 0);
        check("R1 store", store_bits, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        run_cycle("R2 read low",          1, 0, 0, 0, 1, 1, 9'h1A5, 2'b01, 0, 0);
        run_cycle("R2 read high",         1, 0, 1, 0, 0, 1, 9'h0C3, 2'b10, 0, 0);
        run_cycle("R3 local wins",        1, 0, 1, 1, 1, 1, 9'h155, 2'b01, 0, 0);
        run_cycle("R8 src not mem",       1, 0, 0, 0, 0, 0, 9'h0FF, 2'b01, 0, 0);
        run_cycle("R4 write msb1",        0, 1, 0, 1, 1, 1, 9'h111, 2'b10, 1, 0);
        run_cycle("R4 write msb0",        0, 1, 1, 0, 0, 1, 9'h022, 2'b01, 1, 0);
        run_cycle("R9 read busy poke",    1, 0, 1, 0, 0, 1, 9'h1E1, 2'b10, 0, 1);
        run_cycle("R9 write busy poke",   0, 1, 0, 0, 0, 1, 9'h033, 2'b01, 1, 1);
        run_cycle("R11 read over write",  1, 1, 0, 0, 1, 1, 9'h18E, 2'b01, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule